// File: doc/BRIEF.md
# Charge-Transfer Acquisition Sequencer

This block times one capacitive-sense acquisition. An acquisition is a run of charge-transfer cycles. Each cycle has an up phase, a dead half-period, a pass phase and a second dead half-period. While the up phase is active, the enabled transmit lines are driven. At the end of every transfer cycle, each enabled receive channel that is still running adds one to its count and samples its comparator. A comparator trip freezes that channel. The acquisition ends when every enabled channel has either tripped or reached the count limit. A one-cycle end-of-acquisition pulse then reports the end, and the counts and limit flags stay readable until the next start.

All time is kept in half sense-clock periods, so the half-cycle fractions of the phase lengths are exact. The sense clock is the block clock divided by a power of two. When the block starts from its powered-down state, it first waits a selectable regulator settling delay. With the low-power option set, the block returns to that state after every acquisition. With the option clear, the clock and regulator stay on, and the next acquisition starts at once. Channels and transmit lines that are not enabled are either grounded or left floating, as chosen by one select bit per direction.

Top module: `csq_acq_seq`

## Requirements
- R1: A phase code v gives a length of 2v+1 half-ticks when v < 5 and 2^(v-1)+1 half-ticks when v >= 5. A transfer cycle lasts T = up + pass + 2 half-ticks, with one dead half-tick after the up phase and one after the pass phase. `ph_up` and `ph_pass` are high for exactly their phase lengths.
- R2: A half-tick occurs every 2^div_sel clock cycles. Starting from the powered-on idle state with start sampled at clock edge 0, `eoa` is high after edge (S + N·T)·2^div_sel, where S = 0 and N is the number of transfer cycles run.
- R3: A start from the powered-down state first waits S half-ticks before the first up phase. The settling length S is selected by `stab_sel`: 0 selects the long delay (the default setting), 1 selects the medium delay, and 2 or 3 select the short delay.
- R4: When `low_power` is 1, `reg_on` and `sense_clk_en` are both low in the cycle in which `eoa` is high. Counts and limit flags hold their values. The next start pays the settling delay again.
- R5: When `low_power` is 0, `reg_on` and `sense_clk_en` stay high after the acquisition, and the next start pays no settling delay.
- R6: An enabled channel's count equals the number of transfer cycles up to and including the first cycle whose end finds `trip` high. A disabled channel's count stays 0. An accepted start clears all counts and flags.
- R7: The limit L is max(max_val, 1) when `max_en` is 1, and 2^CW-1 otherwise. A channel that reaches count L without a trip stops at L and sets its `limit_hit` bit. A trip in the same cycle takes precedence, and the flag stays clear.
- R8: The acquisition ends at the end of the first transfer cycle after which every enabled channel is finished. With no channel enabled, it ends after one transfer cycle. `eoa` is a single-cycle pulse.
- R9: A start during the settling wait or during an acquisition is ignored, so the timing and counts are unchanged. It also sets `overrun`, which stays set until reset.
- R10: `rx_gnd[i]` is 1 exactly when receive channel i is disabled and `rx_inact_low` is 1. `tx_oe[j]` is `tx_en[j]` OR `tx_inact_low`. `tx_drive[j]` equals `tx_en[j]` during the up phase and is 0 at all other times.
- R11: After reset the block is powered down: `reg_on`, `sense_clk_en`, `eoa`, `overrun`, all counts and all limit flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Acquisition start request |
| div_sel | input | 3 | Sense clock divide exponent |
| up_code | input | 3 | Up phase length code |
| pass_code | input | 3 | Pass phase length code |
| stab_sel | input | 2 | Settling delay select |
| low_power | input | 1 | Power down after each acquisition |
| max_en | input | 1 | Count limit enable |
| max_val | input | CW | Count limit value |
| rx_en | input | NRX | Receive channel enables |
| tx_en | input | NTX | Transmit line enables |
| rx_inact_low | input | 1 | Ground disabled receive pins |
| tx_inact_low | input | 1 | Drive disabled transmit pins low |
| trip | input | NRX | Comparator trip per channel |
| sense_clk_en | output | 1 | Sense clock running |
| reg_on | output | 1 | Sense regulator on |
| ph_up | output | 1 | Up phase active |
| ph_pass | output | 1 | Pass phase active |
| tx_drive | output | NTX | Transmit pin value |
| tx_oe | output | NTX | Transmit pin output enable |
| rx_gnd | output | NRX | Receive pin grounded |
| eoa | output | 1 | End-of-acquisition pulse |
| count_flat | output | NRX*CW | Per-channel counts, channel i at bits [i*CW +: CW] |
| limit_hit | output | NRX | Channel stopped on the limit |
| overrun | output | 1 | Sticky ignored-start flag |

## Verification
The hardest case to reach is a comparator trip that lands on the exact transfer cycle in which the channel also reaches its limit. The trip must be sampled high at that one cycle-end edge, and the edge shifts with the divider, the phase codes and whether a settling wait came first. The bench computes the clock edge of every channel's chosen cycle end from the requirement formulas. It raises that channel's trip in the half-cycle before the edge, across vectors that mix dividers, settling lengths and power states. Ignored starts are placed inside the settling wait and inside a running acquisition, so that any disturbance would appear in the end-pulse timing.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_IDLE, ST_STAB, ST_RUN} csq_state_e;
  typedef enum logic [1:0] {PH_UP, PH_D1, PH_PASS, PH_D2} csq_phase_e;

  // phase length in half sense-clock periods: linear below 5, exponential above
  function automatic logic [6:0] phase_halves(input logic [2:0] code);
    if (code < 3'd5) return 7'((code << 1) + 1);
    return 7'((7'd1 << (code - 3'd1)) + 7'd1);
  endfunction
endpackage

// File: rtl/csq_halftick.sv
module csq_halftick #(
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  localparam int PW = (1 << DIVW) - 1;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  assign mask = (PW'(1) << div) - PW'(1);
  assign tick = run && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart || !run) cnt_q <= '0;
    else                     cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/csq_phase_seq.sv
module csq_phase_seq
  import csq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       tick,
  input  logic [2:0] up_code,
  input  logic [2:0] pass_code,
  output csq_phase_e phase,
  output logic       cycle_end
);
  logic [6:0] rem_q;
  logic [6:0] up_len, pass_len;

  assign up_len    = phase_halves(up_code);
  assign pass_len  = phase_halves(pass_code);
  assign cycle_end = tick && (phase == PH_D2) && (rem_q == 7'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_UP;
      rem_q <= '0;
    end else if (load) begin
      phase <= PH_UP;
      rem_q <= up_len;
    end else if (tick) begin
      if (rem_q == 7'd1) begin
        unique case (phase)
          PH_UP:   begin phase <= PH_D1;   rem_q <= 7'd1;    end
          PH_D1:   begin phase <= PH_PASS; rem_q <= pass_len; end
          PH_PASS: begin phase <= PH_D2;   rem_q <= 7'd1;    end
          default: begin phase <= PH_UP;   rem_q <= up_len;   end
        endcase
      end else begin
        rem_q <= rem_q - 7'd1;
      end
    end
  end
endmodule

// File: rtl/csq_rx_channel.sv
module csq_rx_channel #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cycle_end,
  input  logic          enable,
  input  logic          trip,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          hit,
  output logic          fin_next
);
  logic          done_q;
  logic [CW-1:0] nxt;
  logic          active, at_lim, stop_trip, stop_lim;

  assign nxt       = count + CW'(1);
  assign active    = enable && !done_q;
  assign at_lim    = nxt >= limit;
  assign stop_trip = cycle_end && active && trip;
  assign stop_lim  = cycle_end && active && !trip && at_lim;
  assign fin_next  = !active || stop_trip || stop_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0; done_q <= 1'b0; hit <= 1'b0;
    end else if (clear) begin
      count <= '0; done_q <= 1'b0; hit <= 1'b0;
    end else if (cycle_end && active) begin
      count  <= nxt;
      done_q <= trip || at_lim;
      hit    <= stop_lim;
    end
  end
endmodule

// File: rtl/csq_acq_seq.sv
module csq_acq_seq
  import csq_pkg::*;
#(
  parameter int NRX        = 4,
  parameter int NTX        = 2,
  parameter int CW         = 10,
  parameter int STAB_LONG  = 40,
  parameter int STAB_MED   = 16,
  parameter int STAB_SHORT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        div_sel,
  input  logic [2:0]        up_code,
  input  logic [2:0]        pass_code,
  input  logic [1:0]        stab_sel,
  input  logic              low_power,
  input  logic              max_en,
  input  logic [CW-1:0]     max_val,
  input  logic [NRX-1:0]    rx_en,
  input  logic [NTX-1:0]    tx_en,
  input  logic              rx_inact_low,
  input  logic              tx_inact_low,
  input  logic [NRX-1:0]    trip,
  output logic              sense_clk_en,
  output logic              reg_on,
  output logic              ph_up,
  output logic              ph_pass,
  output logic [NTX-1:0]    tx_drive,
  output logic [NTX-1:0]    tx_oe,
  output logic [NRX-1:0]    rx_gnd,
  output logic              eoa,
  output logic [NRX*CW-1:0] count_flat,
  output logic [NRX-1:0]    limit_hit,
  output logic              overrun
);
  localparam int SW = $clog2(STAB_LONG + STAB_MED + STAB_SHORT + 1);

  csq_state_e    state_q;
  csq_phase_e    phase;
  logic [SW-1:0] stab_q, stab_len;
  logic [CW-1:0] limit;
  logic [NRX-1:0] fin_next;
  logic tick, run_tick, cycle_end, load_ph, stab_end, acq_done;
  logic start_acc, start_ign;

  assign start_acc = start && (state_q == ST_OFF || state_q == ST_IDLE);
  assign start_ign = start && (state_q == ST_STAB || state_q == ST_RUN);
  assign stab_end  = (state_q == ST_STAB) && tick && (stab_q == SW'(1));
  assign load_ph   = (start_acc && state_q == ST_IDLE) || stab_end;
  assign run_tick  = tick && (state_q == ST_RUN);
  assign acq_done  = (state_q == ST_RUN) && cycle_end && (&fin_next);
  assign limit     = !max_en ? '1 : (max_val == '0 ? CW'(1) : max_val);

  always_comb begin
    unique case (stab_sel)
      2'd0:    stab_len = SW'(STAB_LONG);
      2'd1:    stab_len = SW'(STAB_MED);
      default: stab_len = SW'(STAB_SHORT);
    endcase
  end

  csq_halftick #(.DIVW(3)) u_tick (
    .clk, .rst_n, .run(state_q != ST_OFF), .restart(start_acc), .div(div_sel), .tick
  );

  csq_phase_seq u_phase (
    .clk, .rst_n, .load(load_ph), .tick(run_tick), .up_code, .pass_code,
    .phase, .cycle_end
  );

  for (genvar i = 0; i < NRX; i++) begin : g_rx
    csq_rx_channel #(.CW(CW)) u_ch (
      .clk, .rst_n, .clear(start_acc), .cycle_end, .enable(rx_en[i]), .trip(trip[i]),
      .limit, .count(count_flat[i*CW +: CW]), .hit(limit_hit[i]), .fin_next(fin_next[i])
    );
    assign rx_gnd[i] = !rx_en[i] && rx_inact_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      stab_q  <= '0;
      eoa     <= 1'b0;
      overrun <= 1'b0;
    end else begin
      eoa     <= acq_done;
      overrun <= overrun || start_ign;
      unique case (state_q)
        ST_OFF:  if (start_acc) begin state_q <= ST_STAB; stab_q <= stab_len; end
        ST_IDLE: if (start_acc) state_q <= ST_RUN;
        ST_STAB: if (stab_end) state_q <= ST_RUN;
                 else if (tick) stab_q <= stab_q - SW'(1);
        default: if (acq_done) state_q <= low_power ? ST_OFF : ST_IDLE;
      endcase
    end
  end

  assign reg_on       = state_q != ST_OFF;
  assign sense_clk_en = state_q != ST_OFF;
  assign ph_up        = (state_q == ST_RUN) && (phase == PH_UP);
  assign ph_pass      = (state_q == ST_RUN) && (phase == PH_PASS);
  assign tx_drive     = ph_up ? tx_en : '0;
  assign tx_oe        = tx_en | {NTX{tx_inact_low}};
endmodule

// File: rtl/csq_acq_seq_chk.sv
module csq_acq_seq_chk #(
  parameter int NRX = 4,
  parameter int NTX = 2,
  parameter int CW  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eoa,
  input logic              reg_on,
  input logic              sense_clk_en,
  input logic              ph_up,
  input logic              ph_pass,
  input logic              overrun,
  input logic              low_power,
  input logic              cycle_end,
  input logic              start_acc,
  input logic [NRX*CW-1:0] count_flat,
  input logic [NRX-1:0]    limit_hit,
  input logic [NTX-1:0]    tx_drive,
  input logic [NTX-1:0]    tx_oe
);
  assert_eoa_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoa |=> !eoa);

  assert_lp_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoa && $past(low_power) |-> !reg_on && !sense_clk_en);

  assert_no_phase_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_on |-> !ph_up && !ph_pass);

  assert_stay_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoa && !$past(low_power) |-> reg_on && sense_clk_en);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_count_moves_on_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end && !start_acc |=> $stable(count_flat));

  assert_flag_moves_on_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end && !start_acc |=> $stable(limit_hit));

  assert_drive_needs_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_drive & ~tx_oe) == '0);
endmodule

bind csq_acq_seq csq_acq_seq_chk #(.NRX(NRX), .NTX(NTX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eoa(eoa), .reg_on(reg_on), .sense_clk_en(sense_clk_en),
  .ph_up(ph_up), .ph_pass(ph_pass), .overrun(overrun), .low_power(low_power),
  .cycle_end(cycle_end), .start_acc(start_acc), .count_flat(count_flat),
  .limit_hit(limit_hit), .tx_drive(tx_drive), .tx_oe(tx_oe)
);

// File: tb/csq_acq_seq_test.sv
`timescale 1ns/1ps
module csq_acq_seq_test;
  localparam int NRX = 4, NTX = 2, CW = 10;
  localparam int SL = 40, SM = 16, SS = 6;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] div_sel = '0, up_code = '0, pass_code = '0;
  logic [1:0] stab_sel = '0;
  logic low_power = 1'b0, max_en = 1'b0, rx_inact_low = 1'b0, tx_inact_low = 1'b0;
  logic [CW-1:0] max_val = '0;
  logic [NRX-1:0] rx_en = '0, trip = '0;
  logic [NTX-1:0] tx_en = '0;
  logic sense_clk_en, reg_on, ph_up, ph_pass, eoa, overrun;
  logic [NTX-1:0] tx_drive, tx_oe;
  logic [NRX-1:0] rx_gnd, limit_hit;
  logic [NRX*CW-1:0] count_flat;

  always #10 clk = ~clk;

  csq_acq_seq #(.NRX(NRX), .NTX(NTX), .CW(CW), .STAB_LONG(SL), .STAB_MED(SM), .STAB_SHORT(SS)) uut (
    .clk, .rst_n, .start, .div_sel, .up_code, .pass_code, .stab_sel, .low_power, .max_en,
    .max_val, .rx_en, .tx_en, .rx_inact_low, .tx_inact_low, .trip, .sense_clk_en, .reg_on,
    .ph_up, .ph_pass, .tx_drive, .tx_oe, .rx_gnd, .eoa, .count_flat, .limit_hit, .overrun
  );

  typedef struct packed {
    logic [2:0] dv; logic [2:0] up; logic [2:0] ps; logic [1:0] st; logic lp;
    logic men; logic [9:0] mv; logic [3:0] ren;
    logic [5:0] k3; logic [5:0] k2; logic [5:0] k1; logic [5:0] k0;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VT [NV] = '{
    '{3'd0, 3'd1, 3'd1, 2'd0, 1'b0, 1'b0, 10'd0, 4'b1111, 6'd2, 6'd1, 6'd5, 6'd3},
    '{3'd1, 3'd3, 3'd2, 2'd1, 1'b1, 1'b1, 10'd4, 4'b0110, 6'd1, 6'd3, 6'd6, 6'd2},
    '{3'd0, 3'd5, 3'd5, 2'd2, 1'b0, 1'b1, 10'd2, 4'b1001, 6'd0, 6'd0, 6'd0, 6'd2},
    '{3'd2, 3'd0, 3'd7, 2'd3, 1'b1, 1'b1, 10'd0, 4'b0001, 6'd0, 6'd0, 6'd0, 6'd0},
    '{3'd0, 3'd4, 3'd6, 2'd1, 1'b1, 1'b0, 10'd0, 4'b0000, 6'd0, 6'd0, 6'd0, 6'd0},
    '{3'd3, 3'd2, 3'd2, 2'd0, 1'b0, 1'b1, 10'd7, 4'b1111, 6'd2, 6'd0, 6'd8, 6'd7}
  };

  int n_chk = 0, n_bad = 0;
  bit pw_on = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int halves(input int v);
    case (v)
      0: return 1;  1: return 3;  2: return 5;  3: return 7;
      4: return 9;  5: return 17; 6: return 33; default: return 65;
    endcase
  endfunction

  function automatic int settle(input int s);
    if (s == 0) return SL;
    if (s == 1) return SM;
    return SS;
  endfunction

  task automatic run_acq(input vec_t v, input int extra, input string tag);
    int t, s, lim, ncyc, scale, n, ups, pas, txbad;
    int kk[NRX], tgt[NRX], ec[NRX], eh[NRX];
    kk[0] = v.k0; kk[1] = v.k1; kk[2] = v.k2; kk[3] = v.k3;
    t = halves(v.up) + halves(v.ps) + 2;
    s = pw_on ? 0 : settle(v.st);
    lim = v.men ? ((v.mv == 0) ? 1 : int'(v.mv)) : (1 << CW) - 1;
    scale = 1 << v.dv;
    ncyc = 0;
    for (int i = 0; i < NRX; i++) begin
      ec[i] = 0; eh[i] = 0; tgt[i] = 1 << 30;
      if (v.ren[i]) begin
        if (kk[i] != 0 && kk[i] <= lim) begin ec[i] = kk[i]; tgt[i] = (s + kk[i] * t) * scale; end
        else begin ec[i] = lim; eh[i] = 1; end
        if (ec[i] > ncyc) ncyc = ec[i];
      end
    end
    if (ncyc == 0) ncyc = 1;
    @(negedge clk);
    div_sel = v.dv; up_code = v.up; pass_code = v.ps; stab_sel = v.st;
    low_power = v.lp; max_en = v.men; max_val = v.mv; rx_en = v.ren; start = 1'b1;
    n = 0; ups = 0; pas = 0; txbad = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      start = (extra != 0 && n == extra);
      for (int i = 0; i < NRX; i++) trip[i] = (n >= tgt[i]);
      if (ph_up) ups++;
      if (ph_pass) pas++;
      if (tx_drive != (ph_up ? tx_en : '0)) txbad++;
      if (eoa || n > 20000) break;
    end
    trip = '0; start = 1'b0;
    check({tag, " R2 R3 latency"}, n, (s + ncyc * t) * scale + 1);
    check({tag, " R1 up width"}, ups, ncyc * halves(v.up) * scale);
    check({tag, " R1 pass width"}, pas, ncyc * halves(v.ps) * scale);
    check({tag, " R10 tx drive"}, txbad, 0);
    check({tag, " R4 R5 reg_on"}, reg_on, !v.lp);
    check({tag, " R4 R5 clk_en"}, sense_clk_en, !v.lp);
    @(negedge clk);
    check({tag, " R8 eoa pulse"}, eoa, 0);
    for (int i = 0; i < NRX; i++) begin
      check({tag, " R6 R4 count"}, int'(count_flat[i*CW +: CW]), ec[i]);
      check({tag, " R7 limit flag"}, limit_hit[i], eh[i]);
    end
    pw_on = !v.lp;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    vec_t d;
    tx_en = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 reg_on", reg_on, 0);
    check("R11 clk_en", sense_clk_en, 0);
    check("R11 eoa", eoa, 0);
    check("R11 overrun", overrun, 0);
    check("R11 counts", int'(count_flat == '0), 1);
    check("R11 flags", limit_hit, 0);
    check("R11 phases", {ph_up, ph_pass}, 0);

    for (int v = 0; v < NV; v++) begin
      run_acq(VT[v], 0, $sformatf("vec%0d", v));
      check("R9 no overrun", overrun, 0);
    end

    // R4: counts held while powered down
    d = VT[1];
    run_acq(d, 0, "hold");
    repeat (5) @(negedge clk);
    check("R4 held count ch1", int'(count_flat[1*CW +: CW]), 4);
    check("R4 held flag ch1", limit_hit[1], 1);
    check("R4 still off", reg_on, 0);

    // R10 inactive pin selects
    rx_en = 4'b0101; tx_en = 2'b01;
    rx_inact_low = 1'b1; tx_inact_low = 1'b1; #1;
    check("R10 rx_gnd low", rx_gnd, 4'b1010);
    check("R10 tx_oe low", tx_oe, 2'b11);
    rx_inact_low = 1'b0; tx_inact_low = 1'b0; #1;
    check("R10 rx_gnd float", rx_gnd, 4'b0000);
    check("R10 tx_oe float", tx_oe, 2'b01);
    check("R10 tx idle", tx_drive, 2'b00);

    // R9: ignored start during settling (powered down now), then during a run
    d = '{3'd0, 3'd1, 3'd1, 2'd2, 1'b0, 1'b1, 10'd3, 4'b0001, 6'd0, 6'd0, 6'd0, 6'd0};
    run_acq(d, 3, "ovr_stab");
    check("R9 overrun set", overrun, 1);
    run_acq(d, 5, "ovr_run");
    run_acq(d, 0, "ovr_keep");
    check("R9 overrun sticky", overrun, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule